// File: doc/BRIEF.md
# Carry-Controlled Adder-Subtractor

This block is the arithmetic core of a small 8-bit processor. It adds or subtracts two operands and reports the result, the carry out of the top bit and a signed overflow flag. It has no clock and no state: the outputs follow the inputs combinationally. The surrounding flag register and sequencer own the carry between steps.

Subtraction reuses the adder. The B operand is inverted, and the carry input supplies the +1 that completes the two's complement. Each operation comes in two forms. One form chains through the incoming carry flag, so that multi-byte numbers can be processed byte by byte, lowest byte first. The other form overrides the carry with a fixed value, so that the first byte of a chain needs no separate step to set or clear the flag.

The adder is built from cascaded 4-bit slices. Each slice passes its carry to the slice above it.

Top module: `addSubAlu`

## Requirements
- R1: With opCode 2'b00 (plain add), result = (A + B) mod 256 and carryOut = bit 8 of A + B. The carryIn input has no effect on either output.
- R2: With opCode 2'b01 (add through carry), result and carryOut are the low 8 bits and bit 8 of A + B + carryIn.
- R3: With opCode 2'b10 (plain subtract), result = (A − B) mod 256, computed as A + ~B + 1. carryOut is 1 exactly when A ≥ B unsigned, meaning no borrow. The carryIn input has no effect. Example: 0x1C − 0x1B gives 0x01 with carryOut 1.
- R4: With opCode 2'b11 (subtract through carry), result and carryOut are the low 8 bits and bit 8 of A + ~B + carryIn. With carryIn = 1 this equals a plain subtract. With carryIn = 0 it subtracts one more.
- R5: overflow is 1 exactly when bit 7 of A and bit 7 of the adder's B operand are equal and bit 7 of the result differs from them. The B operand is B for add and ~B for subtract. The flag is produced for every operation.
- R6: carryOut and overflow are independent flags. For example, 0x7F + 0x7F in plain add gives 0xFE with overflow 1 and carryOut 0, and 0x80 + 0x80 gives 0x00 with overflow 1 and carryOut 1.
- R7: A carry out of the low 4 bits reaches the upper 4 bits. Example: 0x0F + 0x01 gives 0x10, and 0xFF + 0x01 gives 0x00 with carryOut 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand (subtrahend for subtract) |
| carryIn | input | 1 | Incoming carry flag |
| opCode | input | 2 | 00 add, 01 add through carry, 10 subtract, 11 subtract through carry |
| result | output | 8 | Sum or difference |
| carryOut | output | 1 | Carry out of bit 7 (1 means no borrow on subtract) |
| overflow | output | 1 | Signed overflow |

## Verification
The in-design assertions check, whenever the inputs change, that:
- the sliced carry chain agrees with one wide sum of the effective operands;
- the overflow flag matches the sign rule;
- the carry-override forms give A + B and A − B whatever carryIn is.

Only the bench scenarios can show two further behaviours. One is that the operation code maps onto the intended add or subtract form. The other is that specific corner values come out with the stated flag combinations, such as the signed limits, borrow versus no borrow, and carry across the slice boundary.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_ADC = 2'b01,
    OP_SUB = 2'b10,
    OP_SBC = 2'b11
  } aluOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic invertB;
    logic carrySeed;
  } aluCtrl_t;
endpackage

// File: rtl/aluControl.sv
module aluControl
  import alu_pkg::*;
(
  input  logic [1:0] opCode,
  input  logic       carryIn,
  output aluCtrl_t   ctrl
);
  aluOp_e op;

  always_comb begin
    op = aluOp_e'(opCode);
    ctrl.invertB   = 1'b0;
    ctrl.carrySeed = 1'b0;
    unique case (op)
      OP_ADD: begin ctrl.invertB = 1'b0; ctrl.carrySeed = 1'b0;    end
      OP_ADC: begin ctrl.invertB = 1'b0; ctrl.carrySeed = carryIn; end
      OP_SUB: begin ctrl.invertB = 1'b1; ctrl.carrySeed = 1'b1;    end
      OP_SBC: begin ctrl.invertB = 1'b1; ctrl.carrySeed = carryIn; end
      default: begin ctrl.invertB = 1'b0; ctrl.carrySeed = 1'b0; end
    endcase
  end
endmodule

// File: rtl/aluSlice.sv
module aluSlice #(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] sliceA,
  input  logic [SLICE_W-1:0] sliceB,
  input  logic               sliceCin,
  output logic [SLICE_W-1:0] sliceSum,
  output logic               sliceCout
);
  logic [SLICE_W:0] ripple;

  always_comb begin
    ripple[0] = sliceCin;
    for (int i = 0; i < SLICE_W; i++) begin
      sliceSum[i]   = sliceA[i] ^ sliceB[i] ^ ripple[i];
      ripple[i+1]   = (sliceA[i] & sliceB[i]) | (ripple[i] & (sliceA[i] ^ sliceB[i]));
    end
    sliceCout = ripple[SLICE_W];
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SLICE_W = 4
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluCtrl_t          ctrl,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              overflow
);
  localparam int NUM_SLICES = DATA_W / SLICE_W;
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0]   bOperand;
  logic [NUM_SLICES:0] sliceCarry;
  logic [2:0]          signSel;

  assign bOperand      = ctrl.invertB ? ~opB : opB;
  assign sliceCarry[0] = ctrl.carrySeed;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    aluSlice #(.SLICE_W(SLICE_W)) u_slice (
      .sliceA   (opA[s*SLICE_W +: SLICE_W]),
      .sliceB   (bOperand[s*SLICE_W +: SLICE_W]),
      .sliceCin (sliceCarry[s]),
      .sliceSum (result[s*SLICE_W +: SLICE_W]),
      .sliceCout(sliceCarry[s+1])
    );
  end

  assign carryOut = sliceCarry[NUM_SLICES];

  // Overflow as an eight-entry lookup on the three sign bits
  assign signSel = {opA[MSB], bOperand[MSB], result[MSB]};
  always_comb begin
    case (signSel)
      3'b001:  overflow = 1'b1;
      3'b110:  overflow = 1'b1;
      default: overflow = 1'b0;
    endcase
  end

  always_comb begin
    assert_chain_sum_R2: assert ({carryOut, result} ==
        ({1'b0, opA} + {1'b0, bOperand} + {{DATA_W{1'b0}}, ctrl.carrySeed}))
      else $error("slice chain disagrees with wide sum");
    assert_overflow_rule_R5: assert (overflow ==
        ((opA[MSB] == bOperand[MSB]) && (result[MSB] != opA[MSB])))
      else $error("overflow flag breaks sign rule");
  end
endmodule

// File: rtl/addSubAlu.sv
module addSubAlu
  import alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SLICE_W = 4
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic [1:0]        opCode,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              overflow
);
  aluCtrl_t ctrl;

  aluControl u_control (
    .opCode (opCode),
    .carryIn(carryIn),
    .ctrl   (ctrl)
  );

  aluDatapath #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_datapath (
    .opA     (opA),
    .opB     (opB),
    .ctrl    (ctrl),
    .result  (result),
    .carryOut(carryOut),
    .overflow(overflow)
  );

  always_comb begin
    if (opCode == 2'b00) begin
      assert_add_ignores_carry_R1: assert ({carryOut, result} == ({1'b0, opA} + {1'b0, opB}))
        else $error("plain add depends on carryIn");
    end
    if (opCode == 2'b10) begin
      assert_sub_ignores_carry_R3: assert ((result == DATA_W'(opA - opB)) && (carryOut == (opA >= opB)))
        else $error("plain subtract wrong or borrow flag wrong");
    end
  end
endmodule

// File: tb/addSubAlu_bench.sv
module addSubAlu_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic       carryIn = 1'b0;
  logic [1:0] opCode = 2'b00;
  logic [7:0] result;
  logic       carryOut;
  logic       overflow;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  addSubAlu u_addSubAlu (
    .opA(opA), .opB(opB), .carryIn(carryIn), .opCode(opCode),
    .result(result), .carryOut(carryOut), .overflow(overflow)
  );

  // Behavioural reference: integer arithmetic from the requirements
  task automatic applyCheck(input int a, input int b, input int ci, input int op, input string tag);
    int bEff, cin, sum, expRes, expC, expV;
    @(negedge clk);
    opA = 8'(a); opB = 8'(b); carryIn = ci[0]; opCode = 2'(op);
    bEff = (op >= 2) ? (255 - b) : b;
    case (op)
      0: cin = 0;
      2: cin = 1;
      default: cin = ci;
    endcase
    sum = a + bEff + cin;
    expRes = sum % 256;
    expC = sum / 256;
    expV = (((a / 128) == (bEff / 128)) && ((expRes / 128) != (a / 128))) ? 1 : 0;
    @(posedge clk);
    #1;
    checks++;
    if (result !== 8'(expRes) || carryOut !== expC[0] || overflow !== expV[0]) begin
      failures++;
      $display("FAIL %s: a=%02h b=%02h ci=%0d op=%0d got res=%02h c=%0b v=%0b exp res=%02h c=%0d v=%0d",
               tag, a, b, ci, op, result, carryOut, overflow, expRes, expC, expV);
    end
  endtask

  initial begin : watchdog
    #2000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stimulus
    logic [15:0] lfsr;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // Idle state: all-zero inputs give all-zero outputs (R1)
    applyCheck(0, 0, 0, 0, "R1 idle");
    // R1: carryIn ignored by plain add
    applyCheck(8'h1C, 8'h1C, 1, 0, "R1 add ignores ci");
    applyCheck(8'hF0, 8'h20, 1, 0, "R1 add carry out");
    // R2: add through carry
    applyCheck(8'h1C, 8'h1C, 1, 1, "R2 adc ci=1");
    applyCheck(8'hFF, 8'h00, 1, 1, "R2 adc wrap");
    // R3: plain subtract, carryIn ignored
    applyCheck(8'h1C, 8'h1B, 0, 2, "R3 sub no borrow");
    applyCheck(8'h1B, 8'h1C, 0, 2, "R3 sub borrow");
    applyCheck(8'h40, 8'h40, 0, 2, "R3 sub equal");
    // R4: subtract through carry
    applyCheck(8'h1C, 8'h1B, 1, 3, "R4 sbc ci=1");
    applyCheck(8'h1C, 8'h1B, 0, 3, "R4 sbc ci=0");
    applyCheck(8'h00, 8'h00, 0, 3, "R4 sbc borrow chain");
    // R5: overflow on subtract uses inverted B
    applyCheck(8'h80, 8'h01, 0, 2, "R5 sub neg overflow");
    applyCheck(8'h7F, 8'hFF, 0, 2, "R5 sub pos overflow");
    applyCheck(8'h50, 8'hD0, 0, 0, "R5 mixed signs no overflow");
    // R6: carry versus overflow
    applyCheck(8'h7F, 8'h7F, 0, 0, "R6 127+127");
    applyCheck(8'h80, 8'h80, 0, 0, "R6 -128+-128");
    // R7: nibble carry crossing
    applyCheck(8'h0F, 8'h01, 0, 0, "R7 nibble carry");
    applyCheck(8'hFF, 8'h01, 0, 0, "R7 full ripple");
    // Pseudo-random sweep, every opcode
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      int a, b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = int'(lfsr[7:0]);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = int'(lfsr[7:0]);
      case (i % 4)
        0: applyCheck(a, b, int'(lfsr[9]), 0, "R1 sweep");
        1: applyCheck(a, b, int'(lfsr[9]), 1, "R2 sweep");
        2: applyCheck(a, b, int'(lfsr[9]), 2, "R3 sweep");
        default: applyCheck(a, b, int'(lfsr[9]), 3, "R4 sweep");
      endcase
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule